// File: doc/BRIEF.md
# Phase-Frequency Detector with Pump Mode Control

This block sits in a frequency synthesizer loop. It watches two divided clocks: the output of the reference divider and the output of the feedback divider. It turns the lead or lag between their rising edges into UP (source) and DOWN (sink) requests for a charge pump. When neither request is active, the pump is left in its high-impedance state. Both divided clocks are sampled by the fast system clock through a synchronizer, so all the logic is synchronous. The width of an UP or DOWN pulse equals the phase lead measured in system clock cycles.

A two-bit mode input controls the pump and the amplifier:

- It can turn the pump off completely, which forces both requests inactive.
- Otherwise it selects one of two pump current magnitudes.
- It can also disable the loop-filter amplifier through its own enable output.

The magnitude-select output is retimed so that it only moves while the pump is idle. The analog pump, the filter network and the amplifier are not part of this block. It only drives their digital controls.

Top module: `pfd_pump_ctl`

## Requirements
- R1: A rising edge on `ref_div_i` (held for at least one clock) raises `up_o` on the (SYNC_STAGES+1)-th rising clock edge after the first edge that samples the input high. `up_o` then stays high until a feedback edge is seen.
- R2: A rising edge on `fb_div_i` raises `dn_o` with the same latency as R1. `dn_o` then stays high until a reference edge is seen.
- R3: When the lagging edge is seen, the active request drops in that same cycle. `up_o` and `dn_o` are never high together, edges seen in the same cycle produce no pulse, and the pulse width equals the lead in clock cycles.
- R4: Extra rising edges on the leading input while its request is active keep that request active (frequency-acquisition behaviour).
- R5: The mode encoding is 00 = pump off, 01 = low current, 10 = high current, and 11 = high current with the amplifier off. The `pump_sel_o` encoding is 00 = off, 01 = low, 10 = high, and 11 never appears.
- R6: While `mode_i` is 00, `up_o` and `dn_o` are low from the next clock edge onward. The edge comparison keeps running internally, and falling input edges have no effect.
- R7: `pump_sel_o` takes the level selected by `mode_i` one edge later, but only on an edge where `up_o` and `dn_o` were both low. Otherwise it holds its value.
- R8: `amp_en_o` is low one edge after `mode_i` is 11 and high one edge after any other mode.
- R9: A synchronous active-high `rst` clears `up_o`, `dn_o` and `amp_en_o`, and sets `pump_sel_o` to off (00) on the next edge. It also clears all edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the divided clocks |
| rst | input | 1 | Synchronous active-high reset |
| ref_div_i | input | 1 | Reference-divider output |
| fb_div_i | input | 1 | Feedback-divider output |
| mode_i | input | 2 | Pump and amplifier mode (R5) |
| up_o | output | 1 | Registered source request to the charge pump |
| dn_o | output | 1 | Registered sink request to the charge pump |
| pump_sel_o | output | 2 | Registered pump magnitude select (R5) |
| amp_en_o | output | 1 | Registered loop-filter amplifier enable |

## Verification
The table drives the reference ahead by several margins, the feedback ahead by several margins, and both edges together. Measuring the UP and DOWN high counts separates a correct pulse width from an off-by-one latency, a swapped direction, or a lost coincident-edge case. The same edge patterns are repeated under each of the four modes, which separates gating of the requests from gating of the amplifier and from the magnitude encoding. Directed cases then do the following:

- Repeat a reference edge before the feedback edge arrives.
- Switch the pump off in the middle of a pulse, and change the magnitude in the middle of a pulse, which shows that the select waits for idle while the requests react at once.
- Apply reset while a request is active.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    MODE_OFF       = 2'b00,
    MODE_LO        = 2'b01,
    MODE_HI        = 2'b10,
    MODE_HI_NOAMP  = 2'b11
  } pump_mode_e;

  typedef enum logic [1:0] {
    LVL_OFF = 2'b00,
    LVL_LO  = 2'b01,
    LVL_HI  = 2'b10
  } pump_lvl_e;

  typedef struct packed {
    logic      pump_on;
    pump_lvl_e lvl;
    logic      amp_on;
  } pump_ctl_t;

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic up_nxt,
  output logic dn_nxt
);

  logic up_st, dn_st;
  logic up_raw, dn_raw, clr;

  // A request latches on its own edge; once both would be set, the
  // pair is dropped in the same cycle so they never overlap.
  always_comb begin
    up_raw = up_st | ref_rise;
    dn_raw = dn_st | fb_rise;
    clr    = up_raw & dn_raw;
    up_nxt = up_raw & ~clr;
    dn_nxt = dn_raw & ~clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_st <= 1'b0;
      dn_st <= 1'b0;
    end else begin
      up_st <= up_nxt;
      dn_st <= dn_nxt;
    end
  end

endmodule

// File: rtl/pfd_mode_dec.sv
module pfd_mode_dec
  import pfd_pkg::*;
(
  input  logic [1:0] mode_i,
  output pump_ctl_t  ctl_o
);

  always_comb begin
    unique case (pump_mode_e'(mode_i))
      MODE_OFF:      ctl_o = '{pump_on: 1'b0, lvl: LVL_OFF, amp_on: 1'b1};
      MODE_LO:       ctl_o = '{pump_on: 1'b1, lvl: LVL_LO,  amp_on: 1'b1};
      MODE_HI:       ctl_o = '{pump_on: 1'b1, lvl: LVL_HI,  amp_on: 1'b1};
      MODE_HI_NOAMP: ctl_o = '{pump_on: 1'b1, lvl: LVL_HI,  amp_on: 1'b0};
      default:       ctl_o = '{pump_on: 1'b0, lvl: LVL_OFF, amp_on: 1'b0};
    endcase
  end

endmodule

// File: rtl/pfd_pump_ctl.sv
module pfd_pump_ctl
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_div_i,
  input  logic       fb_div_i,
  input  logic [1:0] mode_i,
  output logic       up_o,
  output logic       dn_o,
  output logic [1:0] pump_sel_o,
  output logic       amp_en_o
);

  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0] raw_in;
  logic [NUM_CH-1:0] rise;
  logic              up_nxt, dn_nxt;
  pump_ctl_t         ctl;
  pump_lvl_e         sel_q;

  assign raw_in = {fb_div_i, ref_div_i};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_edge
    pfd_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .din    (raw_in[ch]),
      .rise_o (rise[ch])
    );
  end

  pfd_core u_core (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (rise[0]),
    .fb_rise  (rise[1]),
    .up_nxt   (up_nxt),
    .dn_nxt   (dn_nxt)
  );

  pfd_mode_dec u_dec (
    .mode_i (mode_i),
    .ctl_o  (ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      up_o     <= 1'b0;
      dn_o     <= 1'b0;
      sel_q    <= LVL_OFF;
      amp_en_o <= 1'b0;
    end else begin
      up_o     <= up_nxt & ctl.pump_on;
      dn_o     <= dn_nxt & ctl.pump_on;
      amp_en_o <= ctl.amp_on;
      if (!up_o && !dn_o) sel_q <= ctl.lvl;
    end
  end

  assign pump_sel_o = sel_q;

endmodule

// File: rtl/pfd_pump_ctl_chk.sv
module pfd_pump_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_i,
  input logic       up_o,
  input logic       dn_o,
  input logic [1:0] pump_sel_o,
  input logic       amp_en_o
);

  p_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(up_o && dn_o));

  p_sel_legal_r5: assert property (@(posedge clk) disable iff (rst)
    pump_sel_o != 2'b11);

  p_off_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00) |=> (!up_o && !dn_o));

  p_sel_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(pump_sel_o) |-> ($past(up_o) == 1'b0 && $past(dn_o) == 1'b0));

  p_amp_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b11) |=> !amp_en_o);

  p_rst_r9: assert property (@(posedge clk)
    rst |=> (!up_o && !dn_o && !amp_en_o && pump_sel_o == 2'b00));

endmodule

bind pfd_pump_ctl pfd_pump_ctl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_i     (mode_i),
  .up_o       (up_o),
  .dn_o       (dn_o),
  .pump_sel_o (pump_sel_o),
  .amp_en_o   (amp_en_o)
);

// File: tb/tb_pfd_pump_ctl.sv
module tb_pfd_pump_ctl;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]        mode;
    logic signed [7:0] lead;
    logic [7:0]        up_w;
    logic [7:0]        dn_w;
    logic [1:0]        sel;
    logic              amp;
  } vec_t;

  // lead > 0: reference ahead by that many cycles; < 0: feedback ahead.
  localparam vec_t VECS [8] = '{
    '{2'b01,  8'sd3, 8'd3, 8'd0, 2'b01, 1'b1},
    '{2'b10, -8'sd5, 8'd0, 8'd5, 2'b10, 1'b1},
    '{2'b11,  8'sd2, 8'd2, 8'd0, 2'b10, 1'b0},
    '{2'b00,  8'sd4, 8'd0, 8'd0, 2'b00, 1'b1},
    '{2'b01,  8'sd0, 8'd0, 8'd0, 2'b01, 1'b1},
    '{2'b10,  8'sd1, 8'd1, 8'd0, 2'b10, 1'b1},
    '{2'b01, -8'sd1, 8'd0, 8'd1, 2'b01, 1'b1},
    '{2'b11, -8'sd7, 8'd0, 8'd7, 2'b10, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_div = 1'b0;
  logic       fb_div = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       up, dn, amp_en;
  logic [1:0] pump_sel;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_pump_ctl #(.SYNC_STAGES(2)) dut (
    .clk        (clk),
    .rst        (rst),
    .ref_div_i  (ref_div),
    .fb_div_i   (fb_div),
    .mode_i     (mode),
    .up_o       (up),
    .dn_o       (dn),
    .pump_sel_o (pump_sel),
    .amp_en_o   (amp_en)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_vec(vec_t v, int idx);
    int ref_t, fb_t, ucnt, dcnt, both;
    mode = v.mode;
    idle(3);
    chk($sformatf("R5 R7 vec%0d pump_sel", idx), pump_sel, v.sel);
    chk($sformatf("R8 vec%0d amp_en", idx), amp_en, v.amp);
    ref_t = (v.lead >= 0) ? 0 : -v.lead;
    fb_t  = (v.lead >= 0) ? v.lead : 0;
    ucnt = 0; dcnt = 0; both = 0;
    for (int t = 0; t < 25; t++) begin
      ref_div = (t >= ref_t);
      fb_div  = (t >= fb_t);
      @(negedge clk);
      if (up) ucnt++;
      if (dn) dcnt++;
      if (up && dn) both++;
    end
    chk($sformatf("R1 R6 vec%0d up width", idx), ucnt, v.up_w);
    chk($sformatf("R2 R6 vec%0d dn width", idx), dcnt, v.dn_w);
    chk($sformatf("R3 vec%0d overlap", idx), both, 0);
    ref_div = 1'b0;
    fb_div  = 1'b0;
    idle(3);
    chk($sformatf("R6 vec%0d falling edges quiet", idx), up | dn, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1, 0);
    report();
  end

  initial begin
    int cnt;
    idle(4);
    // R9: reset state
    chk("R9 reset up", up, 0);
    chk("R9 reset dn", dn, 0);
    chk("R9 reset pump_sel", pump_sel, 0);
    chk("R9 reset amp_en", amp_en, 0);
    rst = 1'b0;
    idle(2);

    for (int i = 0; i < 8; i++) run_vec(VECS[i], i);

    // R1 latency: up appears after exactly three edges
    mode = 2'b01;
    idle(3);
    ref_div = 1'b1;
    idle(2);
    chk("R1 up not yet after two edges", up, 0);
    idle(1);
    chk("R1 up after three edges", up, 1);
    fb_div = 1'b1;
    idle(4);
    chk("R3 up cleared by feedback", up, 0);
    ref_div = 1'b0; fb_div = 1'b0;
    idle(3);

    // R4: repeated reference edge keeps UP active
    cnt = 0;
    for (int t = 0; t < 25; t++) begin
      ref_div = (t < 2) || (t >= 4);
      fb_div  = (t >= 9);
      @(negedge clk);
      if (up) cnt++;
    end
    chk("R4 repeated ref edge up width", cnt, 9);
    ref_div = 1'b0; fb_div = 1'b0;
    idle(3);

    // R6/R7: pump off during a pulse
    mode = 2'b10;
    idle(3);
    ref_div = 1'b1;
    idle(3);
    chk("R1 up before mode off", up, 1);
    mode = 2'b00;
    idle(1);
    chk("R6 up dropped after mode off", up, 0);
    chk("R7 pump_sel held while up was high", pump_sel, 2);
    idle(1);
    chk("R7 pump_sel off once idle", pump_sel, 0);
    fb_div = 1'b1;
    idle(5);
    chk("R6 dn quiet while off", dn, 0);
    ref_div = 1'b0; fb_div = 1'b0;
    idle(3);

    // R7: magnitude change during a DOWN pulse
    mode = 2'b01;
    idle(3);
    fb_div = 1'b1;
    idle(3);
    chk("R2 dn active", dn, 1);
    mode = 2'b10;
    idle(2);
    chk("R7 pump_sel held during dn", pump_sel, 1);
    chk("R2 dn still active", dn, 1);
    ref_div = 1'b1;
    idle(3);
    chk("R3 dn cleared", dn, 0);
    chk("R7 pump_sel not yet updated", pump_sel, 1);
    idle(1);
    chk("R7 pump_sel updated after idle", pump_sel, 2);
    ref_div = 1'b0; fb_div = 1'b0;
    idle(3);

    // R9: reset during an active request
    mode = 2'b11;
    idle(3);
    ref_div = 1'b1;
    idle(3);
    chk("R1 up before reset", up, 1);
    rst = 1'b1;
    ref_div = 1'b0;
    idle(1);
    chk("R9 mid-pulse reset up", up, 0);
    chk("R9 mid-pulse reset pump_sel", pump_sel, 0);
    chk("R9 mid-pulse reset amp_en", amp_en, 0);
    idle(1);
    rst = 1'b0;
    idle(6);
    chk("R9 no request after reset", up | dn, 0);
    chk("R8 amp off in mode 11", amp_en, 0);

    report();
  end

endmodule